// File: doc/BRIEF.md
# Power-Up Reset Delay Sequencer

This block orders the delays a chip must sit through before its core may run. A power-on pulse starts the full chain. First comes a short phase that lets bias circuits settle. Next comes a start-up phase. When the on-chip regulator is in use, this phase is the regulator settling time. When the regulator is off, it is a power-up timer, and a strap can skip that timer altogether. After that the block waits for the selected clock source to report that it is stable. Last comes a configuration-load phase. During that phase the system reset is already released, but the clocks stay gated. Execution is enabled only after every one of these phases has ended.

A reset from any other source is a level request. While the request is high, the block holds the system reset. When the request drops, the block runs only the configuration-load phase and then re-enables execution. A new power-on pulse restarts the full chain from the bias phase, whatever state the block is in.

Every phase length is a parameter given in clock cycles. The surrounding logic does the voltage sensing and runs the oscillator. Both inputs arrive already synchronous to `clk`.

Top module: `pwrseq_top`

## Requirements
Cycle counts are taken from the edge that samples the power-on pulse high, which is edge 0. B, V, P and C stand for the parameters BIAS_CYC, VREG_CYC, PWRT_CYC and CFG_CYC. S is the start-up length chosen by the straps.

- R1: While `rst_n` is low, and on the cycle after any edge that samples `por_pulse_i` high, the outputs read `sys_rst_o`=1, `clk_en_o`=0 and `run_en_o`=0.
- R2: The bias phase always comes first and lasts exactly B cycles. Throughout it, `sys_rst_o` stays 1.
- R3: With `vreg_en_i`=1, S = V. In that case `pwrt_bypass_i` has no effect.
- R4: With `vreg_en_i`=0, S = P when `pwrt_bypass_i`=0. When `pwrt_bypass_i`=1, S = 0 and the start-up phase is skipped.
- R5: In the clock-wait phase, the block leaves only on an edge that samples `clk_ready_i` high. The bench raises `clk_ready_i` so that edge k+1 is the first to sample it high. `sys_rst_o` then reads 0 after edge max(B+S, k)+1.
- R6: The configuration-load phase lasts exactly C cycles, with `sys_rst_o`=0 and `clk_en_o`=0. After a power-on pulse, `run_en_o` reads 1 after edge max(B+S, k)+1+C.
- R7: `run_en_o`=1 only in the run state. In that state `clk_en_o`=1 and `sys_rst_o`=0. `run_en_o` and `sys_rst_o` are never both 1.
- R8: When `rst_req_i` is sampled high while `sys_rst_o`=0, the next cycle shows `sys_rst_o`=1 and `run_en_o`=0. That state holds for as long as the request stays high.
- R9: After `rst_req_i` is sampled low in the held state, `sys_rst_o` reads 0 at once with `clk_en_o`=0. `run_en_o` then rises after C more edges. No bias, start-up or clock-wait phase runs.
- R10: A power-on pulse in any phase, including the start-up phase and the run state, restarts the chain. The timing after the new pulse is the same as after a first pulse.
- R11: A request that is high during the power-up phases does not shorten them. If it is still high when the clock becomes ready, the reset is held until the request drops.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock |
| rst_n | input | 1 | Asynchronous active-low initialisation; places the block in the bias phase |
| por_pulse_i | input | 1 | Power-on pulse, synchronous |
| rst_req_i | input | 1 | Level request from any other reset source |
| vreg_en_i | input | 1 | Strap: on-chip regulator in use |
| pwrt_bypass_i | input | 1 | Strap: skip the power-up timer when the regulator is off |
| clk_ready_i | input | 1 | Selected clock source is stable |
| sys_rst_o | output | 1 | System reset, active high |
| clk_en_o | output | 1 | System clock enable |
| run_en_o | output | 1 | Fetch/run enable; high exactly in the run state |

## Verification
The assertions hold on every cycle for these properties:
- `run_en_o` and `sys_rst_o` are exclusive, and running implies `clk_en_o`.
- A power-on pulse forces the reset state on the next cycle.
- A request that arrives while reset is released brings reset back.
- Every release of reset enters a gated phase.
- Every rise of `run_en_o` follows a timer expiry and a gated stretch of exactly C cycles.

The exact cycle counts of the bias and start-up phases depend on the strap combination and on when the clock becomes ready, so only the bench scenarios can show them. The same holds for the restart of a sequence already in flight and for a reset request that outlasts the power-up chain.

// File: rtl/pwrseq_pkg.sv
package pwrseq_pkg;

  typedef enum logic [2:0] {
    PH_BIAS    = 3'd0,
    PH_START   = 3'd1,
    PH_CLKWAIT = 3'd2,
    PH_CFG     = 3'd3,
    PH_RUN     = 3'd4,
    PH_HOLD    = 3'd5
  } phase_e;

  typedef struct packed {
    logic sys_rst;
    logic clk_en;
    logic run_en;
  } ctl_s;

  // Length of the start-up phase for a given strap setting (0 = skipped).
  function automatic int unsigned startup_len(input logic vreg_on,
                                              input logic pwrt_skip,
                                              input int unsigned vreg_cyc,
                                              input int unsigned pwrt_cyc);
    if (vreg_on)        return vreg_cyc;
    else if (pwrt_skip) return 0;
    else                return pwrt_cyc;
  endfunction

  function automatic int unsigned max4(input int unsigned a, input int unsigned b,
                                       input int unsigned c, input int unsigned d);
    int unsigned m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    return m;
  endfunction

  // Output levels owned by each phase.
  function automatic ctl_s phase_ctl(input phase_e ph);
    ctl_s c;
    case (ph)
      PH_CFG:  c = '{sys_rst: 1'b0, clk_en: 1'b0, run_en: 1'b0};
      PH_RUN:  c = '{sys_rst: 1'b0, clk_en: 1'b1, run_en: 1'b1};
      default: c = '{sys_rst: 1'b1, clk_en: 1'b0, run_en: 1'b0};
    endcase
    return c;
  endfunction

endpackage

// File: rtl/pwrseq_timer.sv
module pwrseq_timer #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic [CNT_W-1:0] term,
  output logic             expired
);

  logic [CNT_W-1:0] cnt_q;

  assign expired = (cnt_q == term);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cnt_q <= '0;
    else if (restart)  cnt_q <= '0;
    else if (!expired) cnt_q <= cnt_q + CNT_W'(1);
  end

endmodule

// File: rtl/pwrseq_fsm.sv
module pwrseq_fsm
  import pwrseq_pkg::*;
#(
  parameter int unsigned BIAS_CYC = 4,
  parameter int unsigned VREG_CYC = 8,
  parameter int unsigned PWRT_CYC = 16,
  parameter int unsigned CFG_CYC  = 4,
  parameter int unsigned CNT_W    = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             por_pulse_i,
  input  logic             rst_req_i,
  input  logic             vreg_en_i,
  input  logic             pwrt_bypass_i,
  input  logic             clk_ready_i,
  input  logic             expired,
  output phase_e           phase_q,
  output logic             restart,
  output logic [CNT_W-1:0] term
);

  localparam logic [CNT_W-1:0] BIAS_TERM = CNT_W'(BIAS_CYC - 1);
  localparam logic [CNT_W-1:0] CFG_TERM  = CNT_W'(CFG_CYC - 1);

  phase_e           phase_d;
  logic [CNT_W-1:0] start_len_q;
  logic [CNT_W-1:0] start_len_now;
  logic             start_skip;

  assign start_len_now = CNT_W'(startup_len(vreg_en_i, pwrt_bypass_i, VREG_CYC, PWRT_CYC));
  assign start_skip    = (start_len_now == '0);

  always_comb begin
    phase_d = phase_q;
    case (phase_q)
      PH_BIAS:    if (expired) phase_d = start_skip ? PH_CLKWAIT : PH_START;
      PH_START:   if (expired) phase_d = PH_CLKWAIT;
      PH_CLKWAIT: if (clk_ready_i) phase_d = rst_req_i ? PH_HOLD : PH_CFG;
      PH_CFG:     if (rst_req_i) phase_d = PH_HOLD;
                  else if (expired) phase_d = PH_RUN;
      PH_RUN:     if (rst_req_i) phase_d = PH_HOLD;
      PH_HOLD:    if (!rst_req_i) phase_d = PH_CFG;
      default:    phase_d = PH_BIAS;
    endcase
    if (por_pulse_i) phase_d = PH_BIAS;
  end

  assign restart = por_pulse_i || (phase_d != phase_q);

  always_comb begin
    case (phase_q)
      PH_BIAS:  term = BIAS_TERM;
      PH_START: term = start_len_q - CNT_W'(1);
      PH_CFG:   term = CFG_TERM;
      default:  term = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q     <= PH_BIAS;
      start_len_q <= '0;
    end else begin
      phase_q <= phase_d;
      if (phase_q == PH_BIAS && expired) start_len_q <= start_len_now;
    end
  end

endmodule

// File: rtl/pwrseq_outdec.sv
module pwrseq_outdec
  import pwrseq_pkg::*;
(
  input  phase_e phase,
  output logic   sys_rst,
  output logic   clk_en,
  output logic   run_en
);

  ctl_s ctl;

  assign ctl     = phase_ctl(phase);
  assign sys_rst = ctl.sys_rst;
  assign clk_en  = ctl.clk_en;
  assign run_en  = ctl.run_en;

endmodule

// File: rtl/pwrseq_top.sv
module pwrseq_top
  import pwrseq_pkg::*;
#(
  parameter int unsigned BIAS_CYC = 500,
  parameter int unsigned VREG_CYC = 2000,
  parameter int unsigned PWRT_CYC = 6400000,
  parameter int unsigned CFG_CYC  = 100
) (
  input  logic clk,
  input  logic rst_n,
  input  logic por_pulse_i,
  input  logic rst_req_i,
  input  logic vreg_en_i,
  input  logic pwrt_bypass_i,
  input  logic clk_ready_i,
  output logic sys_rst_o,
  output logic clk_en_o,
  output logic run_en_o
);

  localparam int unsigned CNT_W = $clog2(max4(BIAS_CYC, VREG_CYC, PWRT_CYC, CFG_CYC) + 1);

  // Named internal events, visible to the bound checker.
  phase_e           phase;
  logic             seq_restart;
  logic             phase_adv;
  logic [CNT_W-1:0] phase_term;

  pwrseq_fsm #(
    .BIAS_CYC (BIAS_CYC),
    .VREG_CYC (VREG_CYC),
    .PWRT_CYC (PWRT_CYC),
    .CFG_CYC  (CFG_CYC),
    .CNT_W    (CNT_W)
  ) fsm_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .por_pulse_i   (por_pulse_i),
    .rst_req_i     (rst_req_i),
    .vreg_en_i     (vreg_en_i),
    .pwrt_bypass_i (pwrt_bypass_i),
    .clk_ready_i   (clk_ready_i),
    .expired       (phase_adv),
    .phase_q       (phase),
    .restart       (seq_restart),
    .term          (phase_term)
  );

  pwrseq_timer #(
    .CNT_W (CNT_W)
  ) timer_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (seq_restart),
    .term    (phase_term),
    .expired (phase_adv)
  );

  pwrseq_outdec outdec_i (
    .phase   (phase),
    .sys_rst (sys_rst_o),
    .clk_en  (clk_en_o),
    .run_en  (run_en_o)
  );

endmodule

// File: rtl/pwrseq_chk.sv
module pwrseq_chk #(
  parameter int unsigned CFG_CYC = 4
) (
  input logic clk,
  input logic rst_n,
  input logic por_pulse_i,
  input logic rst_req_i,
  input logic sys_rst_o,
  input logic clk_en_o,
  input logic run_en_o,
  input logic seq_restart,
  input logic phase_adv
);

  // Length of the current gated-but-released stretch, saturating.
  int unsigned cfg_run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cfg_run_q <= 0;
    else if (!sys_rst_o && !clk_en_o) begin
      if (cfg_run_q <= CFG_CYC) cfg_run_q <= cfg_run_q + 1;
    end else cfg_run_q <= 0;
  end

  // R1
  por_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    por_pulse_i |=> (sys_rst_o && !clk_en_o && !run_en_o));

  // R7
  run_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(sys_rst_o && run_en_o) && (!run_en_o || clk_en_o));

  // R6
  cfg_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sys_rst_o) |-> (!clk_en_o && !run_en_o));

  // R6
  cfg_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(run_en_o) |-> (cfg_run_q == CFG_CYC && $past(phase_adv)));

  // R8
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_req_i && !sys_rst_o && !por_pulse_i) |=> (sys_rst_o && !run_en_o));

  // R10
  out_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sys_rst_o != $past(sys_rst_o)) |-> $past(seq_restart));

endmodule

bind pwrseq_top pwrseq_chk #(.CFG_CYC(CFG_CYC)) chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .por_pulse_i (por_pulse_i),
  .rst_req_i   (rst_req_i),
  .sys_rst_o   (sys_rst_o),
  .clk_en_o    (clk_en_o),
  .run_en_o    (run_en_o),
  .seq_restart (seq_restart),
  .phase_adv   (phase_adv)
);

// File: tb/pwrseq_top_tb_top.sv
module pwrseq_top_tb_top;

  localparam int unsigned T_BIAS = 3;
  localparam int unsigned T_VREG = 5;
  localparam int unsigned T_PWRT = 8;
  localparam int unsigned T_CFG  = 4;

  // vreg, bypass, ready_at, expected release edge, expected run edge
  localparam int NVEC = 7;
  localparam int VEC [NVEC][5] = '{
    '{1, 0,  0,  9, 13},   // R3: regulator settle
    '{0, 0,  0, 12, 16},   // R4: power-up timer
    '{0, 1,  0,  4,  8},   // R4: timer skipped
    '{1, 1,  0,  9, 13},   // R3: bypass ignored with regulator
    '{1, 0, 15, 16, 20},   // R5: late clock
    '{0, 1,  3,  4,  8},   // R5: clock ready exactly at wait entry
    '{0, 0, 20, 21, 25}    // R5: late clock after timer
  };

  logic clk = 1'b0;
  logic rst_n, por_pulse, rst_req, vreg_en, pwrt_bypass, clk_ready;
  logic sys_rst, clk_en, run_en;

  int n_chk  = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  pwrseq_top #(
    .BIAS_CYC (T_BIAS),
    .VREG_CYC (T_VREG),
    .PWRT_CYC (T_PWRT),
    .CFG_CYC  (T_CFG)
  ) dut_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .por_pulse_i   (por_pulse),
    .rst_req_i     (rst_req),
    .vreg_en_i     (vreg_en),
    .pwrt_bypass_i (pwrt_bypass),
    .clk_ready_i   (clk_ready),
    .sys_rst_o     (sys_rst),
    .clk_en_o      (clk_en),
    .run_en_o      (run_en)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Pulse power-on, then count edges until reset release and run enable.
  task automatic run_por(input logic vreg, input logic byp, input int ready_at,
                         input int drop_at, output int rel, output int run,
                         output bit gate_ok);
    int cnt;
    @(negedge clk);
    vreg_en     = vreg;
    pwrt_bypass = byp;
    clk_ready   = 1'b0;
    por_pulse   = 1'b1;
    @(posedge clk);
    @(negedge clk);
    por_pulse = 1'b0;
    cnt = 0; rel = -1; run = -1; gate_ok = 1'b1;
    while (run < 0 && cnt < 400) begin
      if (cnt == ready_at) clk_ready = 1'b1;
      if (cnt == drop_at)  rst_req   = 1'b0;
      if (clk_en && !run_en) gate_ok = 1'b0;
      if (rel < 0 && !sys_rst) rel = cnt;
      if (run_en) run = cnt;
      else begin
        @(posedge clk);
        @(negedge clk);
        cnt++;
      end
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog R5: actual=hung expected=finished");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    int rel, run, cnt;
    bit gate_ok;
    rst_n = 1'b0; por_pulse = 1'b0; rst_req = 1'b0;
    vreg_en = 1'b0; pwrt_bypass = 1'b0; clk_ready = 1'b0;
    repeat (3) @(negedge clk);
    // R1: reset state
    check(sys_rst == 1'b1, "R1", "sys_rst in reset", sys_rst, 1);
    check(clk_en  == 1'b0, "R1", "clk_en in reset", clk_en, 0);
    check(run_en  == 1'b0, "R1", "run_en in reset", run_en, 0);
    rst_n = 1'b1;

    // R2 R3 R4 R5 R6 R7: vector table
    for (int i = 0; i < NVEC; i++) begin
      run_por(VEC[i][0][0], VEC[i][1][0], VEC[i][2], -1, rel, run, gate_ok);
      check(rel == VEC[i][3], "R2/R5", "release edge", rel, VEC[i][3]);
      check(run == VEC[i][4], "R6/R7", "run edge", run, VEC[i][4]);
      check(gate_ok, "R6", "clock gated until run", 0, 1);
    end

    // R8: request from run state
    @(negedge clk);
    rst_req = 1'b1;
    @(posedge clk);
    @(negedge clk);
    check(sys_rst && !run_en && !clk_en, "R8", "reset asserted", sys_rst, 1);
    repeat (5) @(negedge clk);
    check(sys_rst && !run_en, "R8", "reset held", sys_rst, 1);

    // R9: release goes straight to config load
    rst_req = 1'b0;
    @(posedge clk);
    @(negedge clk);
    check(!sys_rst && !clk_en, "R9", "released and gated", sys_rst, 0);
    cnt = 0;
    while (!run_en && cnt < 50) begin
      @(posedge clk);
      @(negedge clk);
      cnt++;
    end
    check(cnt == T_CFG, "R9", "edges to run", cnt, T_CFG);

    // R10: second pulse during start-up phase restarts the chain
    vreg_en = 1'b1; pwrt_bypass = 1'b0; clk_ready = 1'b1;
    por_pulse = 1'b1;
    @(posedge clk);
    @(negedge clk);
    por_pulse = 1'b0;
    repeat (6) @(negedge clk);
    run_por(1'b1, 1'b0, 0, -1, rel, run, gate_ok);
    check(rel == 9, "R10", "release after restart", rel, 9);
    check(run == 13, "R10", "run after restart", run, 13);

    // R11: request high across the power-up chain
    @(negedge clk);
    rst_req = 1'b1;
    run_por(1'b1, 1'b0, 0, 12, rel, run, gate_ok);
    check(rel == 13, "R11", "release after request drop", rel, 13);
    check(run == 17, "R11", "run after request drop", run, 17);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule